// File: doc/BRIEF.md
# AMI composite clock encoder and monitor

This block produces and checks a 64 kHz composite timing clock. The clock is carried as alternate mark inversion, and every 8 kHz frame boundary is marked by a deliberate break in the polarity rule. On the transmit side, each 64 kHz bit tick makes one mark. The mark comes out as a one-cycle enable on either the positive or the negative line driver. The eighth mark of each eight-mark frame repeats the polarity of the seventh mark, so the sign of the violation alternates from one frame to the next.

On the receive side, the block samples the positive and negative pulse detector outputs on each receive bit tick. It hunts for evenly spaced violations and locks onto the frame boundary. Once locked, it emits an 8 kHz frame strobe and flags every sample that departs from the nominal pattern. A rate monitor counts the flagged departures over a programmable window of frames. It raises an alarm when the count exceeds a programmable threshold, and the system can use that alarm to abandon this reference.

The ticks are line timing, not a data stream. The line cannot be stalled, so no pin has valid/ready or back-pressure. Every pin is a plain level or strobe.

Top module: `ami_cc_codec`

## Requirements
- R1: Each `tx_tick` makes exactly one of `tx_pos`/`tx_neg` high for the single clock cycle after the tick. Both outputs stay low in every other cycle.
- R2: Transmit marks alternate in polarity, except that the 8th mark of each 8-mark frame repeats the polarity of the 7th. The first mark after reset is positive. Frames then run + - + - + - + + and - + - + - + - - in turn.
- R3: A receive sample with both `rx_pos` and `rx_neg` high, or both low, is a departure. `rx_departure` pulses in the cycle after that `rx_tick`.
- R4: While unlocked, `rx_locked` rises in the cycle after the 4th violation of a chain in which each violation comes 8 ticks after the one before it. A violation is a valid mark with the same polarity as the previous valid mark, with no invalid sample between the two.
- R5: While locked, `rx_frame_strobe` pulses in the cycle after every tick at the expected boundary position (every 8th tick after lock). It also pulses with the lock-gaining violation. It does not pulse on the tick that loses lock, and it never pulses while unlocked.
- R6: While locked, a violation at a non-boundary position is a departure. A boundary tick without a violation, including an invalid sample there, is also a departure (a miss).
- R7: Two consecutive boundary misses drop `rx_locked` in the cycle after the second miss. That miss is also a departure.
- R8: A clean stream as in R2 produces no departure, both while hunting and while locked.
- R9: Receive ticks are grouped from reset into windows of 8×`cfg_window` ticks (0 counts as 1). Two cycles after the last tick of a window, `rx_alarm` becomes 1 if that window's departures exceed `cfg_threshold`, and 0 otherwise. A departure on the last tick counts in its own window. The alarm holds its value between window ends.
- R10: After reset, `tx_pos`, `tx_neg`, `rx_locked`, `rx_frame_strobe`, `rx_departure` and `rx_alarm` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_tick | input | 1 | 64 kHz transmit bit strobe, one cycle wide |
| tx_pos | output | 1 | Positive mark enable, one cycle |
| tx_neg | output | 1 | Negative mark enable, one cycle |
| rx_tick | input | 1 | Receive bit sampling strobe, one cycle wide |
| rx_pos | input | 1 | Positive pulse detected |
| rx_neg | input | 1 | Negative pulse detected |
| cfg_window | input | WIN_W | Rating window length in frames |
| cfg_threshold | input | CNT_W | Departure count the window may reach without alarm |
| rx_locked | output | 1 | Frame boundary lock |
| rx_frame_strobe | output | 1 | 8 kHz frame strobe |
| rx_departure | output | 1 | One-cycle pulse per departing sample |
| rx_alarm | output | 1 | Departure rate too high |

## Verification
The sharpest coincidence is a departure on the very tick that closes a rating window. The counter has to add that departure and compare the sum in the same step, or the alarm comes out one short. The bench provokes this case in a sweep over every threshold from 0 to 3 and every departure count from 0 to 4 in a one-frame window. It places the invalid samples at the tail of the window, so the last one always falls on the closing tick, and it judges the alarm against count > threshold. A second coincidence is loss of lock and departure on the same boundary tick. The bench judges that tick by requiring a departure with no strobe, and locked low afterwards.

// File: rtl/ami_cc_pkg.sv
package ami_cc_pkg;
  // Marks per 8 kHz frame; the violation position depends on it.
  localparam int FRAME_MARKS = 8;
  localparam int POS_W       = $clog2(FRAME_MARKS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_MARKS - 1);

  // A line sample is a mark only when exactly one detector fired.
  function automatic logic mark_valid(input logic p, input logic n);
    return p ^ n;
  endfunction
endpackage

// File: rtl/ami_cc_tx.sv
module ami_cc_tx
  import ami_cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic mark_pos,
  output logic mark_neg
);
  logic [POS_W-1:0] pos_q;
  logic             pol_q;   // polarity of last mark, 1 = positive
  logic             pol_new;

  // Boundary mark repeats the previous polarity, others invert it.
  assign pol_new = (pos_q == LAST_POS) ? pol_q : ~pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      pol_q    <= 1'b0;
      mark_pos <= 1'b0;
      mark_neg <= 1'b0;
    end else if (tick) begin
      pos_q    <= pos_q + POS_W'(1);
      pol_q    <= pol_new;
      mark_pos <= pol_new;
      mark_neg <= ~pol_new;
    end else begin
      mark_pos <= 1'b0;
      mark_neg <= 1'b0;
    end
  end

  p_onehot_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mark_pos, mark_neg}));
  p_tick_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (mark_pos | mark_neg));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !(mark_pos | mark_neg));
endmodule

// File: rtl/ami_cc_rx_frame.sv
module ami_cc_rx_frame
  import ami_cc_pkg::*;
#(
  parameter int LOCK_COUNT = 4,
  parameter int MISS_COUNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_pos,
  input  logic line_neg,
  output logic locked,
  output logic frame_strobe,
  output logic departure,
  output logic tick_seen
);
  localparam int LW = (LOCK_COUNT > 2) ? $clog2(LOCK_COUNT) : 1;
  localparam int MW = (MISS_COUNT > 2) ? $clog2(MISS_COUNT) : 1;
  localparam logic [LW-1:0] CHAIN_FULL = LW'(LOCK_COUNT - 1);
  localparam logic [MW-1:0] MISS_FULL  = MW'(MISS_COUNT - 1);

  logic [POS_W-1:0] cnt_q, cnt_d;
  logic [LW-1:0]    chain_q, chain_d;
  logic [MW-1:0]    miss_q, miss_d;
  logic             prev_ok_q, prev_ok_d;
  logic             prev_pol_q, prev_pol_d;
  logic             lock_d;
  logic             dep_d, stb_d;
  logic             ok, viol, at_edge;

  assign ok      = mark_valid(line_pos, line_neg);
  assign viol    = ok && prev_ok_q && (line_pos == prev_pol_q);
  assign at_edge = (cnt_q == LAST_POS);

  always_comb begin
    cnt_d      = cnt_q;
    chain_d    = chain_q;
    miss_d     = miss_q;
    prev_ok_d  = prev_ok_q;
    prev_pol_d = prev_pol_q;
    lock_d     = locked;
    dep_d      = 1'b0;
    stb_d      = 1'b0;
    if (tick) begin
      prev_ok_d  = ok;
      prev_pol_d = ok ? line_pos : prev_pol_q;
      if (!ok) dep_d = 1'b1;
      if (locked) begin
        cnt_d = at_edge ? '0 : cnt_q + POS_W'(1);
        if (at_edge) begin
          if (viol) begin
            miss_d = '0;
            stb_d  = 1'b1;
          end else begin
            dep_d = 1'b1;
            if (miss_q == MISS_FULL) begin
              lock_d  = 1'b0;
              chain_d = '0;
              miss_d  = '0;
            end else begin
              miss_d = miss_q + MW'(1);
              stb_d  = 1'b1;
            end
          end
        end else if (viol) begin
          dep_d = 1'b1;
        end
      end else begin
        if (viol) begin
          cnt_d = '0;
          if (at_edge && chain_q != '0) begin
            if (chain_q == CHAIN_FULL) begin
              lock_d  = 1'b1;
              chain_d = '0;
              miss_d  = '0;
              stb_d   = 1'b1;
            end else begin
              chain_d = chain_q + LW'(1);
            end
          end else begin
            chain_d = LW'(1);
          end
        end else begin
          cnt_d = at_edge ? '0 : cnt_q + POS_W'(1);
          if (at_edge) chain_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      chain_q      <= '0;
      miss_q       <= '0;
      prev_ok_q    <= 1'b0;
      prev_pol_q   <= 1'b0;
      locked       <= 1'b0;
      departure    <= 1'b0;
      frame_strobe <= 1'b0;
      tick_seen    <= 1'b0;
    end else begin
      cnt_q        <= cnt_d;
      chain_q      <= chain_d;
      miss_q       <= miss_d;
      prev_ok_q    <= prev_ok_d;
      prev_pol_q   <= prev_pol_d;
      locked       <= lock_d;
      departure    <= dep_d;
      frame_strobe <= stb_d;
      tick_seen    <= tick;
    end
  end

  p_depart_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    departure |-> $past(tick));
  p_invalid_departs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (line_pos == line_neg)) |=> departure);
  p_strobe_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> locked);
  p_lock_gain_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> frame_strobe);
  p_lock_loss_departs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (departure && !frame_strobe));
endmodule

// File: rtl/ami_cc_rx_rate.sv
module ami_cc_rx_rate
  import ami_cc_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             dep_in,
  input  logic [WIN_W-1:0] window,
  input  logic [CNT_W-1:0] threshold,
  output logic             alarm
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [POS_W-1:0] phase_q;
  logic [WIN_W-1:0] frame_q;
  logic [CNT_W-1:0] count_q, total;
  logic             frame_last, win_end;

  assign frame_last = (phase_q == LAST_POS);
  assign win_end    = tick_in && frame_last &&
                      (({1'b0, frame_q} + (WIN_W+1)'(1)) >= {1'b0, window});
  assign total      = (dep_in && count_q != CNT_MAX) ? count_q + CNT_W'(1) : count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      frame_q <= '0;
      count_q <= '0;
      alarm   <= 1'b0;
    end else if (tick_in) begin
      phase_q <= phase_q + POS_W'(1);
      if (win_end) begin
        alarm   <= (total > threshold);
        count_q <= '0;
        frame_q <= '0;
      end else begin
        count_q <= total;
        if (frame_last) frame_q <= frame_q + WIN_W'(1);
      end
    end
  end

  p_alarm_at_window_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm) |-> $past(win_end));
  p_departure_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dep_in |-> tick_in);
endmodule

// File: rtl/ami_cc_codec.sv
module ami_cc_codec
  import ami_cc_pkg::*;
#(
  parameter int LOCK_COUNT = 4,
  parameter int MISS_COUNT = 2,
  parameter int WIN_W      = 8,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_tick,
  output logic             tx_pos,
  output logic             tx_neg,
  input  logic             rx_tick,
  input  logic             rx_pos,
  input  logic             rx_neg,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic [CNT_W-1:0] cfg_threshold,
  output logic             rx_locked,
  output logic             rx_frame_strobe,
  output logic             rx_departure,
  output logic             rx_alarm
);
  logic tick_d;

  ami_cc_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tx_tick),
    .mark_pos (tx_pos),
    .mark_neg (tx_neg)
  );

  ami_cc_rx_frame #(
    .LOCK_COUNT (LOCK_COUNT),
    .MISS_COUNT (MISS_COUNT)
  ) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (rx_tick),
    .line_pos     (rx_pos),
    .line_neg     (rx_neg),
    .locked       (rx_locked),
    .frame_strobe (rx_frame_strobe),
    .departure    (rx_departure),
    .tick_seen    (tick_d)
  );

  ami_cc_rx_rate #(
    .WIN_W (WIN_W),
    .CNT_W (CNT_W)
  ) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_d),
    .dep_in    (rx_departure),
    .window    (cfg_window),
    .threshold (cfg_threshold),
    .alarm     (rx_alarm)
  );
endmodule

// File: tb/ami_cc_codec_bench.sv
module ami_cc_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_tick = 1'b0, rx_tick = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic [7:0] cfg_window = 8'd1, cfg_threshold = 8'd255;
  logic       tx_pos, tx_neg, rx_locked, rx_frame_strobe, rx_departure, rx_alarm;
  logic       s_dep, s_stb, s_lck;
  int         total = 0, fails = 0;

  always #4 clk = ~clk;

  ami_cc_codec u_ami_cc_codec (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .tx_pos(tx_pos), .tx_neg(tx_neg),
    .rx_tick(rx_tick), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .cfg_window(cfg_window), .cfg_threshold(cfg_threshold),
    .rx_locked(rx_locked), .rx_frame_strobe(rx_frame_strobe),
    .rx_departure(rx_departure), .rx_alarm(rx_alarm)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Sign of mark k in a clean stream: 1 = positive (R2).
  function automatic logic sgn(input int k);
    int f, p, q;
    f = k / 8;
    p = k % 8;
    q = (p == 7) ? 6 : p;
    return ((q % 2) == 0) ^ ((f % 2) == 1);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rx_send(input logic p, input logic n);
    @(negedge clk);
    rx_tick = 1'b1; rx_pos = p; rx_neg = n;
    @(negedge clk);
    rx_tick = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    s_dep = rx_departure; s_stb = rx_frame_strobe; s_lck = rx_locked;
    repeat (2) @(negedge clk);
  endtask

  // Receive scenario stimulus and expectations, tick index k from reset.
  function automatic logic [1:0] stim(input int k);
    if (k == 58) return sgn(57) ? 2'b10 : 2'b01;   // misplaced violation
    if (k == 66) return 2'b11;                      // both lines
    if (k == 69 || k == 79 || k == 87) return 2'b00; // no pulse
    return sgn(k) ? 2'b10 : 2'b01;
  endfunction

  function automatic int exp_dep(input int k);
    return int'(k == 58 || k == 59 || k == 66 || k == 69 || k == 79 || k == 87);
  endfunction

  function automatic int exp_lck(input int k);
    return int'((k >= 31 && k < 87) || k >= 119);
  endfunction

  function automatic int exp_stb(input int k);
    return int'(exp_lck(k) == 1 && (k % 8) == 7);
  endfunction

  function automatic string dep_tag(input int k);
    if (k == 66 || k == 69) return "R3";
    if (k == 58 || k == 59 || k == 79) return "R6";
    if (k == 87) return "R7";
    return "R8";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    chk("R10", "tx_pos", int'(tx_pos), 0);
    chk("R10", "tx_neg", int'(tx_neg), 0);
    chk("R10", "locked", int'(rx_locked), 0);
    chk("R10", "strobe", int'(rx_frame_strobe), 0);
    chk("R10", "departure", int'(rx_departure), 0);
    chk("R10", "alarm", int'(rx_alarm), 0);

    // R1, R2: transmit pattern over four frames
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      tx_tick = 1'b1;
      @(negedge clk);
      tx_tick = 1'b0;
      chk("R2", $sformatf("tx_pos mark %0d", k), int'(tx_pos), int'(sgn(k)));
      chk("R1", $sformatf("tx_neg mark %0d", k), int'(tx_neg), int'(!sgn(k)));
      @(negedge clk);
      chk("R1", $sformatf("pulse width mark %0d", k), int'(tx_pos | tx_neg), 0);
    end

    // R3..R8: receive hunt, lock, faults, loss of lock, relock
    for (int k = 0; k < 128; k++) begin
      logic [1:0] s;
      s = stim(k);
      rx_send(s[1], s[0]);
      chk(dep_tag(k), $sformatf("departure tick %0d", k), int'(s_dep), exp_dep(k));
      chk((k == 87) ? "R7" : "R4", $sformatf("locked tick %0d", k), int'(s_lck), exp_lck(k));
      chk("R5", $sformatf("strobe tick %0d", k), int'(s_stb), exp_stb(k));
    end

    // R9: one-frame window, sweep threshold and tail departures
    for (int thr = 0; thr < 4; thr++) begin
      for (int n = 0; n < 5; n++) begin
        cfg_window = 8'd1;
        cfg_threshold = 8'(thr);
        do_reset();
        for (int k = 0; k < 8; k++) begin
          if (k >= 8 - n) rx_send(1'b0, 1'b0);
          else rx_send(sgn(k), !sgn(k));
          if (k == 3)
            chk("R9", $sformatf("mid-window alarm thr %0d n %0d", thr, n), int'(rx_alarm), 0);
        end
        chk("R9", $sformatf("alarm thr %0d n %0d", thr, n), int'(rx_alarm), int'(n > thr));
      end
    end

    // R9: two-frame window closes only after 16 ticks
    cfg_window = 8'd2;
    cfg_threshold = 8'd0;
    do_reset();
    for (int k = 0; k < 16; k++) begin
      if (k == 3) rx_send(1'b1, 1'b1);
      else rx_send(sgn(k), !sgn(k));
      if (k == 7) chk("R9", "alarm before two-frame window end", int'(rx_alarm), 0);
    end
    chk("R9", "alarm at two-frame window end", int'(rx_alarm), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule